// File: doc/BRIEF.md
# Interrupt Claim/Complete Arbiter

This block tracks the pending and in-service state of a set of level-triggered interrupt sources and shares them among several targets, called contexts. Source IDs start at 1. ID 0 is reserved and means "nothing". Each source has a request line and a 3-bit priority. Each context brings its own enable mask and priority threshold. For every context the block drives a registered interrupt line and the ID of the best source that context could take right now.

A context handler takes a source with a one-cycle claim strobe, tagged with its context index. The block answers on the next cycle with the chosen ID. It also moves that source from pending into the in-service set, which hides it from every context. When the handler is done, a complete strobe that names the ID releases the source. Claims are accepted every cycle, with no back-pressure. The response is a single-cycle valid pulse with no ready, so the requester must capture it when it comes.

Each context is built as either a machine-mode or a supervisor-mode target. Its interrupt is routed to the matching one of two output vectors.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source's pending bit is its request line registered on each clock edge. The request line of ID 0 is ignored, so ID 0 is never pending.
- R2: A source is eligible for a context only when it is pending, not in service, and the context's enable bit for its ID is 1.
- R3: `ctx_irq[c]` is 1 exactly when some eligible source has a priority strictly greater than `ctx_thresh` of context c.
- R4: A claim, and `ctx_best` for each context, select the eligible source with the highest priority above the threshold. When priorities are equal, the lowest ID wins.
- R5: A claim that finds a source clears that source's pending bit and sets its in-service bit in the same edge. The source is then masked for every context until it is completed.
- R6: A claim that finds no qualifying source responds with ID 0 and changes no pending or in-service state.
- R7: A complete with an ID from 1 to NUM_ID-1 clears that source's in-service bit. A complete naming ID 0 or an ID of NUM_ID or above has no effect.
- R8: A claim or complete whose context index is NCTX or above is ignored. Such a claim produces no response.
- R9: Bit c of `CTX_MACH_MASK` set to 1 makes context c a machine context. Its interrupt then appears on `ext_irq_m[c]`, and `ext_irq_s[c]` stays 0. A 0 routes the interrupt to `ext_irq_s[c]` instead.
- R10: All outputs are registered. `resp_valid` and `resp_id` appear on the cycle after the claim strobe. `ctx_irq`, `ctx_best` and the external lines reflect a claim, a complete or a change of request, enable or threshold from the same edge.
- R11: While reset is asserted and right after it, all pending and in-service bits and all outputs are 0.
- R12: A claim and a complete on the same edge both take effect. If both name the same source, the claim wins and the source stays in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_ID | Level request per source ID (bit 0 ignored) |
| src_prio | input | NUM_ID*PW | Priority per source ID, PW bits each |
| ctx_en | input | NCTX*NUM_ID | Enable mask per context, NUM_ID bits each |
| ctx_thresh | input | NCTX*PW | Threshold per context |
| claim_valid | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Context index of the claim |
| cmpl_valid | input | 1 | Complete strobe |
| cmpl_ctx | input | CTX_W | Context index of the complete |
| cmpl_id | input | ID_W | Source ID being completed |
| ctx_irq | output | NCTX | Interrupt per context |
| ctx_best | output | NCTX*ID_W | Best eligible ID per context, 0 if none |
| ext_irq_m | output | NCTX | Interrupts of machine contexts |
| ext_irq_s | output | NCTX | Interrupts of supervisor contexts |
| resp_valid | output | 1 | Claim response valid |
| resp_id | output | ID_W | Claimed ID, 0 if none qualified |

## Verification
A claim and a complete can hit the same edge. The claim sets one in-service bit while the complete clears another, or both try to act on the same source. The bench provokes both cases. It claims for one context while completing a source that a second context has enabled. It then checks that the claimed ID comes back and that the second context's best ID switches to the released source on the same cycle. A long mixed phase fires claims and completes with random IDs and context indices, including out-of-range ones, on the same cycles. Every output is compared with a reference model built from the requirements.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  typedef enum logic {CTX_SUP = 1'b0, CTX_MACH = 1'b1} ctx_mode_e;

  // width able to carry IDs 0..n, so the value n itself is representable
  function automatic int id_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_ID = 8,
  parameter int PW     = 3,
  parameter int ID_W   = 4
) (
  input  logic [NUM_ID-1:0]    elig,
  input  logic [NUM_ID*PW-1:0] prio,
  input  logic [PW-1:0]        thresh,
  output logic [ID_W-1:0]      id,
  output logic                 hit
);
  // strict compare in ascending order keeps the lowest ID on equal priority
  always_comb begin
    logic [PW-1:0] best_p;
    best_p = thresh;
    id     = '0;
    for (int i = 0; i < NUM_ID; i++) begin
      if (elig[i] && (prio[i*PW +: PW] > best_p)) begin
        best_p = prio[i*PW +: PW];
        id     = ID_W'(i);
      end
    end
    hit = (id != '0);
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int NUM_ID = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_ID-1:0] src_req,
  input  logic              claim_hit,
  input  logic [ID_W-1:0]   claim_id,
  input  logic              cmpl_go,
  input  logic [ID_W-1:0]   cmpl_id,
  output logic [NUM_ID-1:0] pend_q,
  output logic [NUM_ID-1:0] insvc_q,
  output logic [NUM_ID-1:0] pend_d,
  output logic [NUM_ID-1:0] insvc_d
);
  logic unused_req0;
  assign unused_req0 = src_req[0];

  assign pend_d[0]  = 1'b0;
  assign insvc_d[0] = 1'b0;

  for (genvar i = 1; i < NUM_ID; i++) begin : g_src
    logic taken, freed;
    assign taken      = claim_hit && (claim_id == ID_W'(i));
    assign freed      = cmpl_go && (cmpl_id == ID_W'(i));
    assign pend_d[i]  = src_req[i] && !taken;
    assign insvc_d[i] = (insvc_q[i] && !freed) || taken;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

  AST_TAKEN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    claim_hit |-> !insvc_q[claim_id[$clog2(NUM_ID)-1:0]]) else $error("claimed an in-service source"); // R2
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import irqarb_pkg::*;
#(
  parameter int               NUM_ID        = 8,
  parameter int               NCTX          = 3,
  parameter int               PW            = 3,
  parameter logic [NCTX-1:0]  CTX_MACH_MASK = 3'b101,
  parameter int               ID_W          = id_width(NUM_ID),
  parameter int               CTX_W         = id_width(NCTX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_ID-1:0]      src_req,
  input  logic [NUM_ID*PW-1:0]   src_prio,
  input  logic [NCTX*NUM_ID-1:0] ctx_en,
  input  logic [NCTX*PW-1:0]     ctx_thresh,
  input  logic                   claim_valid,
  input  logic [CTX_W-1:0]       claim_ctx,
  input  logic                   cmpl_valid,
  input  logic [CTX_W-1:0]       cmpl_ctx,
  input  logic [ID_W-1:0]        cmpl_id,
  output logic [NCTX-1:0]        ctx_irq,
  output logic [NCTX*ID_W-1:0]   ctx_best,
  output logic [NCTX-1:0]        ext_irq_m,
  output logic [NCTX-1:0]        ext_irq_s,
  output logic                   resp_valid,
  output logic [ID_W-1:0]        resp_id
);
  localparam int IDX_W = $clog2(NUM_ID);

  logic [NUM_ID-1:0] pend_q, insvc_q, pend_d, insvc_d;
  logic              claim_go, cmpl_go, claim_hit;
  logic [ID_W-1:0]   claim_id;
  logic [NUM_ID-1:0] sel_en;
  logic [PW-1:0]     sel_thr;

  assign claim_go = claim_valid && (claim_ctx < CTX_W'(NCTX));
  assign cmpl_go  = cmpl_valid && (cmpl_ctx < CTX_W'(NCTX)) &&
                    (cmpl_id != '0) && (cmpl_id < ID_W'(NUM_ID));

  // pick the claiming context's mask and threshold
  always_comb begin
    sel_en  = '0;
    sel_thr = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (claim_ctx == CTX_W'(c)) begin
        sel_en  = ctx_en[c*NUM_ID +: NUM_ID];
        sel_thr = ctx_thresh[c*PW +: PW];
      end
    end
  end

  logic              pick_hit;
  logic [NUM_ID-1:0] claim_elig;
  assign claim_elig = pend_q & ~insvc_q & sel_en;

  irq_pick #(.NUM_ID(NUM_ID), .PW(PW), .ID_W(ID_W)) u_claim_pick (
    .elig(claim_elig), .prio(src_prio), .thresh(sel_thr),
    .id(claim_id), .hit(pick_hit)
  );
  assign claim_hit = claim_go && pick_hit;

  irq_state #(.NUM_ID(NUM_ID), .ID_W(ID_W)) u_state (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .claim_hit(claim_hit), .claim_id(claim_id),
    .cmpl_go(cmpl_go), .cmpl_id(cmpl_id),
    .pend_q(pend_q), .insvc_q(insvc_q), .pend_d(pend_d), .insvc_d(insvc_d)
  );

  // per-context view computed on the next state, so outputs land with it
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    localparam ctx_mode_e MODE = ctx_mode_e'(CTX_MACH_MASK[c]);
    logic [NUM_ID-1:0] nxt_elig;
    logic [ID_W-1:0]   nxt_id;
    logic              nxt_hit;

    assign nxt_elig = pend_d & ~insvc_d & ctx_en[c*NUM_ID +: NUM_ID];

    irq_pick #(.NUM_ID(NUM_ID), .PW(PW), .ID_W(ID_W)) u_pick (
      .elig(nxt_elig), .prio(src_prio), .thresh(ctx_thresh[c*PW +: PW]),
      .id(nxt_id), .hit(nxt_hit)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctx_irq[c]                <= 1'b0;
        ctx_best[c*ID_W +: ID_W]  <= '0;
        ext_irq_m[c]              <= 1'b0;
        ext_irq_s[c]              <= 1'b0;
      end else begin
        ctx_irq[c]                <= nxt_hit;
        ctx_best[c*ID_W +: ID_W]  <= nxt_id;
        ext_irq_m[c]              <= nxt_hit && (MODE == CTX_MACH);
        ext_irq_s[c]              <= nxt_hit && (MODE == CTX_SUP);
      end
    end

    AST_BEST_MEANS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_best[c*ID_W +: ID_W] != '0) |-> ctx_irq[c]) else $error("best without irq"); // R3
    AST_BEST_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_best[c*ID_W +: ID_W] != '0) |-> !insvc_q[ctx_best[c*ID_W +: IDX_W]]) else $error("best in service"); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_id    <= '0;
    end else begin
      resp_valid <= claim_go;
      resp_id    <= claim_hit ? claim_id : '0;
    end
  end

  AST_RESP_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(claim_valid)) else $error("response without claim"); // R10
  AST_CLAIM_SETS_INSVC: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_id != '0) |-> insvc_q[resp_id[IDX_W-1:0]]) else $error("claimed not in service"); // R5
  AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_id != '0) |-> !pend_q[resp_id[IDX_W-1:0]]) else $error("claimed still pending"); // R5
  AST_EMPTY_CLAIM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_id == '0 && !$past(cmpl_go)) |-> (insvc_q == $past(insvc_q))) else $error("empty claim moved state"); // R6
  AST_CMPL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_go |=> (!insvc_q[$past(cmpl_id[IDX_W-1:0])] ||
                 (resp_valid && resp_id == $past(cmpl_id)))) else $error("complete did not release"); // R7
  AST_ID0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_req[0]) |-> !pend_q[0]) else $error("ID 0 pending"); // R1
endmodule

// File: tb/tb_irq_claim_arbiter.sv
module tb_irq_claim_arbiter;
  localparam int CLK_P = 10;
  localparam int NI = 8, NC = 3, PW = 3, IW = 4, CW = 2;
  localparam logic [NC-1:0] MACH = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] src_req = '0;
  logic [NI*PW-1:0] src_prio = '0;
  logic [NC*NI-1:0] ctx_en = '0;
  logic [NC*PW-1:0] ctx_thresh = '0;
  logic claim_valid = 1'b0, cmpl_valid = 1'b0;
  logic [CW-1:0] claim_ctx = '0, cmpl_ctx = '0;
  logic [IW-1:0] cmpl_id = '0;
  logic [NC-1:0] ctx_irq, ext_irq_m, ext_irq_s;
  logic [NC*IW-1:0] ctx_best;
  logic resp_valid;
  logic [IW-1:0] resp_id;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [NI-1:0] m_pend = '0, m_insvc = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  irq_claim_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
    .ctx_en(ctx_en), .ctx_thresh(ctx_thresh),
    .claim_valid(claim_valid), .claim_ctx(claim_ctx),
    .cmpl_valid(cmpl_valid), .cmpl_ctx(cmpl_ctx), .cmpl_id(cmpl_id),
    .ctx_irq(ctx_irq), .ctx_best(ctx_best), .ext_irq_m(ext_irq_m),
    .ext_irq_s(ext_irq_s), .resp_valid(resp_valid), .resp_id(resp_id)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_pick(input logic [NI-1:0] pd, input logic [NI-1:0] sv,
                                  input logic [NI-1:0] en, input int thr);
    int best = thr, id = 0;
    for (int i = 1; i < NI; i++) begin
      int p = int'(src_prio[i*PW +: PW]);
      if (pd[i] && !sv[i] && en[i] && p > best) begin best = p; id = i; end
    end
    return id;
  endfunction

  function automatic logic [31:0] nxt_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // one clock with the current inputs; strobes drop afterwards
  task automatic tick();
    logic go;
    int cid;
    logic [NI-1:0] np, ns;
    int eb [NC];
    go  = claim_valid && (claim_ctx < NC);
    cid = go ? ref_pick(m_pend, m_insvc, ctx_en[claim_ctx*NI +: NI],
                        int'(ctx_thresh[claim_ctx*PW +: PW])) : 0;
    np = src_req & 8'hFE;
    ns = m_insvc;
    if (cmpl_valid && cmpl_ctx < NC && cmpl_id != 0 && cmpl_id < NI) ns[cmpl_id[2:0]] = 1'b0;
    if (cid != 0) begin np[cid] = 1'b0; ns[cid] = 1'b1; end
    for (int c = 0; c < NC; c++)
      eb[c] = ref_pick(np, ns, ctx_en[c*NI +: NI], int'(ctx_thresh[c*PW +: PW]));
    @(posedge clk);
    m_pend = np; m_insvc = ns;
    @(negedge clk);
    chk(int'(resp_valid), int'(go), "R10 resp_valid");
    chk(int'(resp_id), cid, "R4 R6 resp_id");
    for (int c = 0; c < NC; c++) begin
      chk(int'(ctx_best[c*IW +: IW]), eb[c], "R4 ctx_best");
      chk(int'(ctx_irq[c]), int'(eb[c] != 0), "R3 ctx_irq");
      chk(int'(ext_irq_m[c]), int'(eb[c] != 0 && MACH[c]), "R9 ext_irq_m");
      chk(int'(ext_irq_s[c]), int'(eb[c] != 0 && !MACH[c]), "R9 ext_irq_s");
    end
    claim_valid = 1'b0;
    cmpl_valid  = 1'b0;
  endtask

  task automatic do_claim(input int c);
    claim_valid = 1'b1; claim_ctx = CW'(c);
  endtask

  task automatic do_cmpl(input int c, input int id);
    cmpl_valid = 1'b1; cmpl_ctx = CW'(c); cmpl_id = IW'(id);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R11: reset, inputs busy
    src_req = 8'hFF; ctx_en = '1; src_prio = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(ctx_irq), 0, "R11 irq in reset");
    chk(int'(ctx_best), 0, "R11 best in reset");
    chk(int'(resp_valid), 0, "R11 resp in reset");
    src_req = '0; ctx_en = '0; src_prio = '0;
    rst_n = 1'b1;
    tick();
    chk(int'({ext_irq_m, ext_irq_s}), 0, "R11 after reset");

    // priorities equal to the ID
    for (int i = 0; i < NI; i++) src_prio[i*PW +: PW] = PW'(i);
    ctx_en[0 +: NI] = 8'hFE;

    // R1
    src_req = 8'h04; tick();
    chk(int'(ctx_best[0 +: IW]), 2, "R1 request sets pending");
    src_req = 8'h00; tick();
    chk(int'(ctx_irq[0]), 0, "R1 low request clears pending");
    src_req = 8'h01; ctx_en[0 +: NI] = 8'hFF; tick();
    chk(int'(ctx_irq[0]), 0, "R1 ID 0 never pending");

    // R2
    src_req = 8'h08; ctx_en[0 +: NI] = 8'hF6; tick();
    chk(int'(ctx_irq[0]), 0, "R2 disabled source");
    ctx_en[0 +: NI] = 8'hFE; tick();
    chk(int'(ctx_best[0 +: IW]), 3, "R2 enabled source");

    // R3 threshold sweep on source 5 (priority 5)
    src_req = 8'h20;
    for (int t = 0; t < 8; t++) begin
      ctx_thresh[0 +: PW] = PW'(t); tick();
      chk(int'(ctx_irq[0]), int'(5 > t), "R3 strict threshold");
    end
    ctx_thresh = '0;

    // R4 tie: all priorities 3, sources 3 and 5
    for (int i = 0; i < NI; i++) src_prio[i*PW +: PW] = 3'd3;
    ctx_en = {8'h00, 8'hFE, 8'hFE};
    src_req = 8'h28; tick();
    do_claim(0); tick();
    chk(int'(resp_id), 3, "R4 tie lowest ID");
    chk(int'(ctx_best[IW +: IW]), 5, "R5 claimed masked for other context");
    do_claim(1); tick();
    chk(int'(resp_id), 5, "R5 second claim");
    do_claim(0); tick();
    chk(int'(resp_id), 0, "R6 empty claim");
    chk(int'(ctx_irq[1:0]), 0, "R6 no state change");

    // R7 / R8 completes
    do_cmpl(0, 0); tick();
    chk(int'(ctx_irq[0]), 0, "R7 complete of ID 0 ignored");
    do_cmpl(0, 9); tick();
    chk(int'(ctx_irq[0]), 0, "R7 complete of large ID ignored");
    do_cmpl(3, 3); tick();
    chk(int'(ctx_irq[0]), 0, "R8 complete with bad context ignored");
    do_cmpl(2, 3); tick();
    chk(int'(ctx_best[0 +: IW]), 3, "R7 complete releases");

    // R12 claim 3 while completing 5
    do_claim(0); do_cmpl(1, 5); tick();
    chk(int'(resp_id), 3, "R12 claim beside complete");
    chk(int'(ctx_best[IW +: IW]), 5, "R12 complete beside claim");
    // R12 complete and claim on one source: claim wins
    do_cmpl(2, 3); tick();
    do_claim(1); do_cmpl(0, 3); tick();
    chk(int'(resp_id), 3, "R12 same source claimed");
    chk(int'(ctx_best[0 +: IW]), 5, "R12 claim wins over complete");

    // R8 claim with bad context
    do_claim(3); tick();
    chk(int'(resp_valid), 0, "R8 bad context claim");

    // R9 routing
    ctx_en = '1; src_req = 8'h40; do_cmpl(0, 3); tick();
    do_cmpl(0, 5); tick();
    chk(int'({ext_irq_m[0], ext_irq_s[1]}), 3, "R9 mode routing");

    // mixed sweep
    for (int k = 0; k < 5000; k++) begin
      rng = nxt_rng(rng);
      if (rng[3:0] == 0) src_req = rng[15:8];
      if (rng[7:4] == 1) src_prio = {rng[31:16], rng[23:16]};
      if (rng[7:4] == 2) ctx_en = {rng[31:8]};
      if (rng[7:4] == 3) ctx_thresh = rng[24:16];
      if (rng[8]) do_claim(int'(rng[10:9]));
      if (rng[11]) do_cmpl(int'(rng[13:12]), int'(rng[19:16]));
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule